// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits on the processor side of a shared address/data bus and turns single transfer requests into timed bus cycles. A request gives an address, a read or write direction, a memory or I/O space select and, for writes, the data to store. The block places the address on the shared lines for one clock and pulses an address latch enable so that external logic can hold it. It then switches the lines to the data phase, asserts the matching active-low strobe and the active-low data enable, and finishes with a quiet clock in which every strobe is released.

Slow devices stretch a transfer by holding the READY input low. READY is first examined at the close of the second state. While it stays low, wait states are inserted, and READY is examined again in each of them. Read data is captured from the shared lines at the close of the third state. It is returned together with a one-cycle done pulse in the final state, and a following request may start in that same cycle.

Top module: `mux_bus_seq`

## Requirements
- R1: While rst is high at a clock edge, the next cycle shows the idle state: ale=0, rd_n=1, wr_n=1, den_n=1, bus_oe=0, rsp_done=0 and req_ready=1.
- R2: In the first state (T1) of a cycle, ale=1, bus_oe=1, bus_out carries the request address, rd_n, wr_n and den_n are all 1, xmit_dir equals the write flag (1 = write, 0 = read) and io_sel equals the space flag (1 = I/O, 0 = memory).
- R3: From the second state (T2) until the end of T3, ale=0, den_n=0, and exactly one strobe is low: rd_n for a read or wr_n for a write. A write drives its data zero-extended on bus_out with bus_oe=1. A read keeps bus_oe=0.
- R4: READY is sampled at the end of T2 and at the end of every wait state. Each low sample adds one wait state with the data-phase outputs unchanged, so a transfer with n low samples lasts 4+n cycles from T1 to T4.
- R5: A read returns in rsp_rdata the low DATA_W bits that bus_in held at the end of T3. Values on bus_in at other times have no effect on the result.
- R6: In the final state (T4), rd_n, wr_n and den_n are 1 and bus_oe=0, so a write strobe rises as T4 begins.
- R7: rsp_done is high for exactly one cycle, in T4. req_ready is high only in idle and in T4.
- R8: A request presented while a cycle is between T1 and T3 is ignored. The current transfer's address, data, strobes and result are unaffected, and ale stays 0.
- R9: A request present in T4 is accepted, and the next cycle is T1 of the new transfer with no idle cycle between them.
- R10: xmit_dir and io_sel hold constant from T1 through T4 of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted in this cycle if req_valid is high |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid while rsp_done is high |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| ale | output | 1 | Address latch enable, high in T1 |
| xmit_dir | output | 1 | Bus direction, 1 = transmit (write) |
| io_sel | output | 1 | Space select, 1 = I/O |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| den_n | output | 1 | Active-low data enable |
| bus_out | output | ADDR_W | Value driven onto the shared lines |
| bus_oe | output | 1 | Output enable of the shared lines |
| bus_in | input | ADDR_W | Value read from the shared lines |
| ready | input | 1 | Device ready, low inserts wait states |

## Verification
The bench builds the block with a 12-bit address and an 8-bit data path. This selects the zero-extending data alignment and lets a read capture only the low bits while the upper lines carry noise. The short address lets a 16-word device model in the bench decode the latched address. Writes and reads then revisit the same words many times, so data written over the bus is read back through it. Wait counts from zero to five, requests arriving mid-cycle, back-to-back requests and a reset inside a wait state are all within reach at this size.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TW   = 3'd3,
      ST_T3   = 3'd4,
      ST_T4   = 3'd5
   } bus_state_e;
endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
   import mbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       req_valid,
   input  logic       ready,
   output bus_state_e state,
   output logic       accept
);
   bus_state_e state_nx;

   // requests are taken only when no cycle is in flight or the last one closes
   assign accept = req_valid && (state == ST_IDLE || state == ST_T4);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (accept) state_nx = ST_T1;
         ST_T1:   state_nx = ST_T2;
         ST_T2:   state_nx = ready ? ST_T3 : ST_TW;
         ST_TW:   state_nx = ready ? ST_T3 : ST_TW;
         ST_T3:   state_nx = ST_T4;
         ST_T4:   state_nx = accept ? ST_T1 : ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_nx;
   end
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [DATA_W-1:0] req_wdata,
   input  bus_state_e        state,
   input  logic [ADDR_W-1:0] bus_in,
   output logic              lat_write,
   output logic              lat_io,
   output logic [ADDR_W-1:0] bus_out,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int PAD_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] lat_wdata;
   logic [ADDR_W-1:0] wdata_bus;

   generate
      if (PAD_W == 0) begin : g_full_width
         assign wdata_bus = lat_wdata;
      end else begin : g_zero_ext
         assign wdata_bus = {{PAD_W{1'b0}}, lat_wdata};
      end
   endgenerate

   // address in T1, data for the remainder of the cycle
   assign bus_out = (state == ST_T1) ? lat_addr : wdata_bus;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_addr  <= '0;
         lat_wdata <= '0;
         lat_write <= 1'b0;
         lat_io    <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_write <= req_write;
            lat_io    <= req_io;
         end
         if (state == ST_T3 && !lat_write) rsp_rdata <= bus_in[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              ale,
   output logic              xmit_dir,
   output logic              io_sel,
   output logic              rd_n,
   output logic              wr_n,
   output logic              den_n,
   output logic [ADDR_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [ADDR_W-1:0] bus_in,
   input  logic              ready
);
   generate
      if (DATA_W > ADDR_W || DATA_W < 1) begin : g_bad_width
         $error("mux_bus_seq: DATA_W must lie in 1..ADDR_W");
      end
   endgenerate

   bus_state_e state;
   logic       accept;
   logic       lat_write;
   logic       lat_io;
   logic       active;
   logic       data_phase;

   mbs_fsm u_fsm (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .ready     (ready),
      .state     (state),
      .accept    (accept)
   );

   mbs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_write (req_write),
      .req_io    (req_io),
      .req_wdata (req_wdata),
      .state     (state),
      .bus_in    (bus_in),
      .lat_write (lat_write),
      .lat_io    (lat_io),
      .bus_out   (bus_out),
      .rsp_rdata (rsp_rdata)
   );

   assign active     = (state != ST_IDLE);
   assign data_phase = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);

   assign ale       = (state == ST_T1);
   assign rd_n      = !(data_phase && !lat_write);
   assign wr_n      = !(data_phase && lat_write);
   assign den_n     = !data_phase;
   assign bus_oe    = ale || (data_phase && lat_write);
   assign xmit_dir  = active && lat_write;
   assign io_sel    = active && lat_io;
   assign rsp_done  = (state == ST_T4);
   assign req_ready = (state == ST_IDLE) || (state == ST_T4);
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
   input logic clk,
   input logic rst,
   input logic ale,
   input logic rd_n,
   input logic wr_n,
   input logic den_n,
   input logic bus_oe,
   input logic xmit_dir,
   input logic io_sel,
   input logic rsp_done,
   input logic req_ready
);
   // R2
   ale_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
      ale |-> (bus_oe && rd_n && wr_n && den_n));

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n));

   // R3
   den_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !den_n |-> (!rd_n || !wr_n));

   // R6
   done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_done |-> (rd_n && wr_n && den_n && !bus_oe && !ale));

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_done |=> !rsp_done);

   // R7
   done_ready_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_done |-> req_ready);

   // R10
   dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !den_n |-> ($stable(xmit_dir) && $stable(io_sel)));
endmodule

bind mux_bus_seq mbs_checker u_chk (
   .clk       (clk),
   .rst       (rst),
   .ale       (ale),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .den_n     (den_n),
   .bus_oe    (bus_oe),
   .xmit_dir  (xmit_dir),
   .io_sel    (io_sel),
   .rsp_done  (rsp_done),
   .req_ready (req_ready)
);

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_io = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_done;
   logic          ale, xmit_dir, io_sel, rd_n, wr_n, den_n, bus_oe;
   logic [AW-1:0] bus_out;
   logic [AW-1:0] bus_in = '0;
   logic          ready = 1'b1;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [DW-1:0] dev_mem [16];
   logic [DW-1:0] ref_mem [16];

   always #10 clk = ~clk;

   mux_bus_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
      .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .ale(ale), .xmit_dir(xmit_dir), .io_sel(io_sel), .rd_n(rd_n),
      .wr_n(wr_n), .den_n(den_n), .bus_out(bus_out), .bus_oe(bus_oe),
      .bus_in(bus_in), .ready(ready)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ext_data(input logic [DW-1:0] d);
      return {{(AW-DW){1'b0}}, d};
   endfunction

   task automatic idle_outputs(input string tag);
      chk({tag, " ale"}, ale, 1'b0);
      chk({tag, " rd_n"}, rd_n, 1'b1);
      chk({tag, " wr_n"}, wr_n, 1'b1);
      chk({tag, " den_n"}, den_n, 1'b1);
      chk({tag, " bus_oe"}, bus_oe, 1'b0);
      chk({tag, " rsp_done"}, rsp_done, 1'b0);
      chk({tag, " req_ready"}, req_ready, 1'b1);
   endtask

   task automatic data_phase(input logic w, input logic [DW-1:0] wd, input string tag);
      chk({tag, " R3 ale"}, ale, 1'b0);
      chk({tag, " R3 den_n"}, den_n, 1'b0);
      chk({tag, " R3 rd_n"}, rd_n, w);
      chk({tag, " R3 wr_n"}, wr_n, !w);
      chk({tag, " R3 bus_oe"}, bus_oe, w);
      if (w) chk({tag, " R3 bus_out"}, bus_out, ext_data(wd));
      chk({tag, " R7 done"}, rsp_done, 1'b0);
      chk({tag, " R7 req_ready"}, req_ready, 1'b0);
   endtask

   // caller enters at a negedge (idle or T4); returns at the T4 negedge
   task automatic xfer(input logic [AW-1:0] a, input logic w, input logic io,
                       input logic [DW-1:0] wd, input int nw, input bit poke);
      int idx;
      req_valid = 1'b1; req_addr = a; req_write = w; req_io = io; req_wdata = wd;
      @(negedge clk); // T1
      req_valid = 1'b0;
      chk("R2 ale", ale, 1'b1);
      chk("R2 bus_oe", bus_oe, 1'b1);
      chk("R2 bus_out address", bus_out, a);
      chk("R2 strobes idle", {rd_n, wr_n, den_n}, 3'b111);
      chk("R2 xmit_dir", xmit_dir, w);
      chk("R2 io_sel", io_sel, io);
      chk("R9 R7 req_ready low in T1", req_ready, 1'b0);
      idx = int'(bus_out[3:0]);
      ready = 1'($urandom); // not sampled in T1
      @(negedge clk); // T2
      data_phase(w, wd, "T2");
      if (poke) begin
         req_valid = 1'b1; req_addr = ~a; req_write = !w; req_wdata = ~wd; // R8
      end
      bus_in = AW'($urandom);
      ready = (nw == 0);
      for (int i = 0; i < nw; i++) begin
         @(negedge clk); // wait state
         data_phase(w, wd, "R4 wait");
         chk("R10 R4 dir held", {xmit_dir, io_sel}, {w, io});
         bus_in = AW'($urandom);
         ready = (i == nw - 1);
      end
      @(negedge clk); // T3
      data_phase(w, wd, "R4 T3");
      chk("R8 ale stays low", ale, 1'b0);
      req_valid = 1'b0;
      if (w) dev_mem[idx] = bus_out[DW-1:0];
      else   bus_in = {4'($urandom), dev_mem[idx]};
      ready = 1'($urandom);
      @(negedge clk); // T4
      chk("R6 strobes released", {rd_n, wr_n, den_n}, 3'b111);
      chk("R6 bus_oe", bus_oe, 1'b0);
      chk("R7 done in T4", rsp_done, 1'b1);
      chk("R7 req_ready in T4", req_ready, 1'b1);
      chk("R10 dir held in T4", {xmit_dir, io_sel}, {w, io});
      if (w) ref_mem[a[3:0]] = wd;
      else   chk("R5 read data", rsp_rdata, ref_mem[a[3:0]]);
      bus_in = AW'($urandom);
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         idle_outputs("R9 idle");
      end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5eed));
      for (int i = 0; i < 16; i++) begin dev_mem[i] = '0; ref_mem[i] = '0; end
      repeat (3) @(negedge clk);
      idle_outputs("R1 reset");
      rst = 1'b0;
      @(negedge clk);
      idle_outputs("R1 after reset");

      // directed corner cases
      xfer(12'h3A5, 1'b1, 1'b0, 8'hC3, 0, 1'b0); // write, no waits
      idle_cycles(1);
      xfer(12'h7A5, 1'b0, 1'b0, 8'h00, 0, 1'b0); // R5 read back, no waits
      idle_cycles(1);
      xfer(12'h012, 1'b1, 1'b1, 8'h5A, 3, 1'b1); // R4 R8 I/O write, waits, poke
      xfer(12'h012, 1'b0, 1'b1, 8'h00, 5, 1'b1); // R9 back-to-back read
      xfer(12'hFFF, 1'b1, 1'b0, 8'hFF, 1, 1'b0); // R9 back-to-back write
      idle_cycles(2);

      // random mix
      for (int n = 0; n < 80; n++) begin
         xfer(AW'($urandom), 1'($urandom), 1'($urandom), DW'($urandom),
              int'($urandom % 4), 1'($urandom));
         idle_cycles(int'($urandom % 3));
      end

      // R1 reset inside a wait state
      req_valid = 1'b1; req_addr = 12'h444; req_write = 1'b1; req_wdata = 8'h99;
      @(negedge clk);
      req_valid = 1'b0; ready = 1'b0;
      @(negedge clk); // T2
      @(negedge clk); // wait
      rst = 1'b1;
      @(negedge clk);
      idle_outputs("R1 mid-cycle reset");
      rst = 1'b0; ready = 1'b1;
      @(negedge clk);
      idle_outputs("R1 idle after mid reset");
      xfer(12'h444, 1'b0, 1'b0, 8'h00, 2, 1'b0);
      idle_cycles(1);
      finish_run();
   end
endmodule